// File: doc/BRIEF.md
# Programming-Mode Entry Pulse Counter

This block decides, once per reset, whether the device starts normally or enters its on-board programming mode. If it enters programming mode, the block also decides which serial channel the programming link uses.

The decision rests on a single high-voltage mode pin, which reaches the logic as a digital level. The pin passes through a two-flop synchronizer and then a counter-based glitch filter. After reset is released, the block waits a hold-off time and checks that the pin is already high. It then counts qualified low-going pulses on the pin during a fixed window. Every phase that ends inside the window must be at least a minimum width. When the window closes, the block evaluates the count and latches one of four results: normal run, 3-wire serial programming, UART programming, or invalid.

All times are given in nanoseconds and converted to clock cycles as ceil(ns × CLK_MHZ / 1000), with a minimum of one cycle. This gives four cycle counts, referred to below by these names:
- HOLD: the hold-off after reset release.
- WIN: the counting window.
- MINW: the minimum phase width.
- GLT: the glitch-filter length.

Edges are counted on the system clock, with edge 1 being the first rising clock edge on which reset is seen high.

Top module: `prog_entry_detect`

## Requirements
- R1: While reset is asserted, `mode_o` is 0, and `done_o`, `done_stb_o` and `err_o` are all 0.
- R2: If the filtered pin level is low at the end of the hold-off, the block reports normal run (code 0) with `err_o` at 0. In this case `done_stb_o` is high for the single cycle after edge HOLD+1.
- R3: If the pin is high at the end of the hold-off and stays high for the whole window, the block reports 3-wire serial programming (code 1) with `err_o` at 0.
- R4: Exactly 8 qualified pulses inside the window select UART programming (code 2) with `err_o` at 0. A pulse is a low phase followed by a return to high.
- R5: A pin level change that lasts fewer than GLT cycles has no effect on the count, the width checks or the result. A change that lasts GLT cycles or more is taken as a real level change.
- R6: A pulse count other than 0 or 8 gives invalid (code 3) with `err_o` at 1.
- R7: If any high or low phase that ends inside the window is shorter than MINW cycles, the result is invalid (code 3) with `err_o` at 1. A phase of exactly MINW cycles is accepted.
- R8: If the pin is low when the window closes, the result is invalid (code 3) with `err_o` at 1.
- R9: When the block enters programming evaluation, `done_stb_o` is high for exactly the one cycle after edge HOLD+WIN+1. `done_o` is high from that cycle onward. `mode_o` and `err_o` then hold their values until the next reset, and pin activity after that point has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously and released on a clock edge. Its release starts the hold-off. |
| hv_mode_i | input | 1 | Digital level of the high-voltage mode pin (1 = high voltage present) |
| done_o | output | 1 | High from the moment the result is final |
| done_stb_o | output | 1 | Single-cycle strobe when the result is latched |
| mode_o | output | 2 | Result: 0 = run, 1 = 3-wire serial, 2 = UART, 3 = invalid |
| err_o | output | 1 | High when the result is invalid |

## Verification
Each result becomes visible exactly once, at a cycle fixed by reset release. For a failed entry check, the strobe is high in the cycle after edge HOLD+1. Otherwise it is high in the cycle after edge HOLD+WIN+1, and `mode_o` and `err_o` change in that same cycle. The bench counts edges from release and compares all four outputs against that expected cycle on every falling clock edge. Before the strobe, the outputs must show the reset values; after it, they must show the latched result.

Pulses are placed well clear of the window boundaries. The synchronizer and the glitch filter delay both edges of a phase by the same number of cycles. Because of this, a pin phase driven for N cycles is measured as exactly N cycles, so the MINW and GLT boundaries are tested at their exact values.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_SER3 = 2'd1,
    PM_UART = 2'd2,
    PM_BAD  = 2'd3
  } pmode_t;

  typedef enum logic [1:0] {
    SQ_HOLD = 2'd0,
    SQ_WIN  = 2'd1,
    SQ_EVAL = 2'd2,
    SQ_DONE = 2'd3
  } sq_t;

  // Convert a time in ns to clock cycles, rounding up, with a floor of one cycle.
  function automatic int ns_to_cyc(int mhz, int ns);
    longint prod;
    int     c;
    prod = longint'(ns) * longint'(mhz);
    c    = int'((prod + 64'sd999) / 64'sd1000);
    return (c < 1) ? 1 : c;
  endfunction

  // Map a final pulse count to a result code.
  function automatic pmode_t count_to_mode(int cnt, int ser3_n, int uart_n);
    if (cnt == ser3_n)      return PM_SER3;
    else if (cnt == uart_n) return PM_UART;
    else                    return PM_BAD;
  endfunction

endpackage

// File: rtl/pe_sync_filter.sv
module pe_sync_filter #(
  parameter int GLT_C = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int GW = (GLT_C < 2) ? 1 : $clog2(GLT_C + 1);

  logic          s1, s2;
  logic [GW-1:0] gcnt;
  logic          settle;

  // The synchronized level must differ from the filtered level for GLT_C cycles in a row.
  assign settle = (s2 != lvl_o) && (gcnt == GW'(GLT_C - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      lvl_o  <= 1'b0;
      gcnt   <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      s1     <= pin_i;
      s2     <= s1;
      rise_o <= settle && s2;
      fall_o <= settle && !s2;
      if (s2 == lvl_o) begin
        gcnt <= '0;
      end else if (settle) begin
        lvl_o <= s2;
        gcnt  <= '0;
      end else begin
        gcnt <= gcnt + GW'(1);
      end
    end
  end

  // An edge strobe always agrees with the new filtered level.
  p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> lvl_o);
  p_fall_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !lvl_o);

  generate
    if (GLT_C >= 2) begin : g_reject
      // A filtered change requires the synchronized level to have held for at least two samples.
      p_reject_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> ($past(s2) && $past(s2, 2)));
      p_reject_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lvl_o) |-> (!$past(s2) && !$past(s2, 2)));
    end
  endgenerate

endmodule

// File: rtl/pe_width_meter.sv
module pe_width_meter #(
  parameter int MINW_C = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic len_ok_o
);
  localparam int WW = $clog2(MINW_C + 1);

  // Cycles in the current phase, saturating at MINW_C.
  // In the first cycle of a new phase it still holds the length of the phase that just ended.
  logic [WW-1:0] wid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid <= '0;
    end else if (edge_i) begin
      wid <= WW'(1);
    end else if (wid != WW'(MINW_C)) begin
      wid <= wid + WW'(1);
    end
  end

  assign len_ok_o = (wid >= WW'(MINW_C));

  p_wid_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wid <= WW'(MINW_C));
  p_wid_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> (wid == WW'(1)));

endmodule

// File: rtl/pe_sequencer.sv
module pe_sequencer
  import pe_pkg::*;
#(
  parameter int HOLD_C = 8,
  parameter int WIN_C  = 16000,
  parameter int SER3_N = 0,
  parameter int UART_N = 8,
  parameter int CNT_W  = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl_i,
  input  logic   rise_i,
  input  logic   fall_i,
  input  logic   len_ok_i,
  output logic   done_o,
  output logic   done_stb_o,
  output pmode_t mode_o,
  output logic   err_o,
  output logic   entry_ok_o
);
  localparam int HW = $clog2(HOLD_C + 1);
  localparam int WW = $clog2(WIN_C + 1);

  sq_t              state;
  logic [HW-1:0]    hcnt;
  logic [WW-1:0]    wcnt;
  logic [CNT_W-1:0] cnt;
  logic             viol;
  logic             ev_bad_width;
  logic             ev_good_pulse;
  pmode_t           cnt_mode;

  assign ev_bad_width  = (state == SQ_WIN) && (rise_i || fall_i) && !len_ok_i;
  assign ev_good_pulse = (state == SQ_WIN) && rise_i && len_ok_i;
  assign cnt_mode      = count_to_mode(int'(cnt), SER3_N, UART_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_HOLD;
      hcnt       <= '0;
      wcnt       <= '0;
      cnt        <= '0;
      viol       <= 1'b0;
      entry_ok_o <= 1'b0;
      done_o     <= 1'b0;
      done_stb_o <= 1'b0;
      mode_o     <= PM_RUN;
      err_o      <= 1'b0;
    end else begin
      case (state)
        SQ_HOLD: begin
          if (hcnt == HW'(HOLD_C - 1)) begin
            entry_ok_o <= lvl_i;
            state      <= lvl_i ? SQ_WIN : SQ_EVAL;
          end else begin
            hcnt <= hcnt + HW'(1);
          end
        end
        SQ_WIN: begin
          if (ev_bad_width) viol <= 1'b1;
          if (ev_good_pulse && (cnt != {CNT_W{1'b1}})) cnt <= cnt + CNT_W'(1);
          if (wcnt == WW'(WIN_C - 1)) state <= SQ_EVAL;
          else                        wcnt  <= wcnt + WW'(1);
        end
        SQ_EVAL: begin
          state      <= SQ_DONE;
          done_o     <= 1'b1;
          done_stb_o <= 1'b1;
          if (!entry_ok_o) begin
            mode_o <= PM_RUN;
            err_o  <= 1'b0;
          end else if (viol || !lvl_i) begin
            mode_o <= PM_BAD;
            err_o  <= 1'b1;
          end else begin
            mode_o <= cnt_mode;
            err_o  <= (cnt_mode == PM_BAD);
          end
        end
        SQ_DONE: begin
          done_stb_o <= 1'b0;
        end
        default: state <= SQ_HOLD;
      endcase
    end
  end

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb_o |=> !done_stb_o);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> ($stable(mode_o) && $stable(err_o)));
  p_count_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ($past(state) == SQ_WIN));
  p_entry_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb_o && !entry_ok_o) |-> (mode_o == PM_RUN && !err_o));
  p_width_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb_o && viol) |-> (mode_o == PM_BAD));

endmodule

// File: rtl/prog_entry_detect.sv
module prog_entry_detect #(
  parameter int CLK_MHZ     = 8,
  parameter int START_NS    = 1000,
  parameter int WINDOW_NS   = 2000000,
  parameter int MINW_NS     = 8000,
  parameter int GLITCH_NS   = 40,
  parameter int SER3_PULSES = 0,
  parameter int UART_PULSES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hv_mode_i,
  output logic       done_o,
  output logic       done_stb_o,
  output logic [1:0] mode_o,
  output logic       err_o
);
  localparam int HOLD_C = pe_pkg::ns_to_cyc(CLK_MHZ, START_NS);
  localparam int WIN_C  = pe_pkg::ns_to_cyc(CLK_MHZ, WINDOW_NS);
  localparam int MINW_C = pe_pkg::ns_to_cyc(CLK_MHZ, MINW_NS);
  localparam int GLT_C  = pe_pkg::ns_to_cyc(CLK_MHZ, GLITCH_NS);
  localparam int CNT_W  = $clog2(UART_PULSES + 2);

  logic           f_lvl, f_rise, f_fall, len_ok, entry_ok;
  pe_pkg::pmode_t mode_e;

  pe_sync_filter #(.GLT_C(GLT_C)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (hv_mode_i),
    .lvl_o  (f_lvl),
    .rise_o (f_rise),
    .fall_o (f_fall)
  );

  pe_width_meter #(.MINW_C(MINW_C)) u_wid (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (f_rise | f_fall),
    .len_ok_o (len_ok)
  );

  pe_sequencer #(
    .HOLD_C (HOLD_C),
    .WIN_C  (WIN_C),
    .SER3_N (SER3_PULSES),
    .UART_N (UART_PULSES),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_i      (f_lvl),
    .rise_i     (f_rise),
    .fall_i     (f_fall),
    .len_ok_i   (len_ok),
    .done_o     (done_o),
    .done_stb_o (done_stb_o),
    .mode_o     (mode_e),
    .err_o      (err_o),
    .entry_ok_o (entry_ok)
  );

  assign mode_o = mode_e;

  // The strobe of a failed entry comes at hold-off end, long before the window could close.
  p_quick_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_stb_o && !entry_ok) |-> (mode_o == 2'd0));

endmodule

// File: tb/sim_prog_entry_detect.sv
module sim_prog_entry_detect;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 50;
  localparam int START_NS   = 400;
  localparam int WIN_NS     = 60000;
  localparam int MINW_NS    = 1000;
  localparam int GLT_NS     = 40;

  function automatic int cyc_of(int ns);
    int v;
    v = (ns * MHZ + 999) / 1000;
    if (v < 1) v = 1;
    return v;
  endfunction

  localparam int T_HOLD = cyc_of(START_NS);
  localparam int T_WIN  = cyc_of(WIN_NS);
  localparam int T_MINW = cyc_of(MINW_NS);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0;
  logic       done, done_stb, err;
  logic [1:0] mode;

  int         cyc = 0;
  int         n_chk = 0;
  int         n_err = 0;
  string      tag = "R1";
  int         exp_done = 0;
  logic [1:0] exp_mode = 2'd0;
  logic       exp_err = 1'b0;
  bit         mon_on = 1'b0;
  bit         over = 1'b0;

  prog_entry_detect #(
    .CLK_MHZ   (MHZ),
    .START_NS  (START_NS),
    .WINDOW_NS (WIN_NS),
    .MINW_NS   (MINW_NS),
    .GLITCH_NS (GLT_NS)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .hv_mode_i  (pin),
    .done_o     (done),
    .done_stb_o (done_stb),
    .mode_o     (mode),
    .err_o      (err)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  // Reference: before the expected edge all outputs are idle; at it the strobe fires; after it the result holds.
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      logic [4:0] got, want;
      got  = {done_stb, done, mode, err};
      want = {(cyc == exp_done), (cyc >= exp_done),
              (cyc >= exp_done) ? exp_mode : 2'd0,
              (cyc >= exp_done) ? exp_err : 1'b0};
      n_chk++;
      if (got !== want) begin
        n_err++;
        $display("FAIL %s cyc=%0d stb/done/mode/err got %b expected %b", tag, cyc, got, want);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic start_case(string t, logic pin0, logic [1:0] m, logic e, bit entry);
    mon_on = 1'b0;
    rst_n  = 1'b0;
    pin    = pin0;
    tick(3);
    n_chk++;  // R1: reset state
    if ({done_stb, done, mode, err} !== 5'b0) begin
      n_err++;
      $display("FAIL R1 reset outputs got %b expected 00000", {done_stb, done, mode, err});
    end
    tag      = t;
    exp_mode = m;
    exp_err  = e;
    exp_done = entry ? (T_HOLD + T_WIN + 1) : (T_HOLD + 1);
    mon_on   = 1'b1;
    rst_n    = 1'b1;
    tick(T_HOLD + T_MINW + 20);
  endtask

  task automatic finish_case();
    while (cyc < exp_done + 6) tick(1);
    mon_on = 1'b0;
  endtask

  task automatic dip(int lo, int hi);
    pin = 1'b0; tick(lo);
    pin = 1'b1; tick(hi);
  endtask

  // A dip whose low phase holds a high spike and whose high phase holds a low spike, each gw cycles wide.
  task automatic dip_spiky(int lo, int hi, int gw);
    pin = 1'b0; tick(lo / 2);
    pin = 1'b1; tick(gw);
    pin = 1'b0; tick(lo - lo / 2 - gw);
    pin = 1'b1; tick(hi / 2);
    pin = 1'b0; tick(gw);
    pin = 1'b1; tick(hi - hi / 2 - gw);
  endtask

  initial begin
    // R2: pin low at release, so the result is normal run right after the hold-off
    start_case("R2", 1'b0, 2'd0, 1'b0, 1'b0);
    finish_case();

    // R3: pin held high with no pulses selects the 3-wire serial channel
    start_case("R3", 1'b1, 2'd1, 1'b0, 1'b1);
    finish_case();

    // R4: eight clean pulses select UART
    start_case("R4", 1'b1, 2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) dip(60, 60);
    finish_case();

    // R5: one-cycle spikes (shorter than the filter) leave the count of eight intact
    start_case("R5", 1'b1, 2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) dip_spiky(80, 80, 1);
    finish_case();

    // R5: a spike exactly at the filter length passes and breaks the width rule
    start_case("R5", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) dip(60, 60);
    dip_spiky(80, 80, 2);
    finish_case();

    // R6: three pulses is an illegal count
    start_case("R6", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) dip(60, 60);
    finish_case();

    // R6: nine pulses is an illegal count
    start_case("R6", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 9; i++) dip(60, 60);
    finish_case();

    // R7: phases of exactly the minimum width are accepted
    start_case("R7", 1'b1, 2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) dip(T_MINW, T_MINW);
    finish_case();

    // R7: a low phase one cycle short of the minimum is rejected
    start_case("R7", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) dip((i == 3) ? T_MINW - 1 : 60, 60);
    finish_case();

    // R7: a high phase one cycle short of the minimum is rejected
    start_case("R7", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) dip(60, (i == 4) ? T_MINW - 1 : 60);
    finish_case();

    // R8: pin left low at window close
    start_case("R8", 1'b1, 2'd3, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) dip(60, 60);
    pin = 1'b0;
    finish_case();

    // R9: the result holds after the strobe while the pin keeps pulsing
    start_case("R9", 1'b1, 2'd2, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) dip(60, 60);
    while (cyc < exp_done + 2) tick(1);
    for (int i = 0; i < 4; i++) dip(60, 60);
    dip(5, 7);
    tick(100);
    mon_on = 1'b0;

    over = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!over) begin
      over = 1'b1;
      n_err++;
      $display("FAIL watchdog tag=%s cyc=%0d got no end expected finish", tag, cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule